// File: doc/BRIEF.md
# Rotating Register File Renamer

This block is a register file split into a static region and a rotating region. All ports use logical register numbers. A logical number below the static count addresses a static entry directly. A higher logical number is first reduced by the static count. The rotating base is then added to it, modulo the rotating-region size, to pick a physical rotating entry. When the loop body ends, a rotate strobe lowers the base by one. A value written under one logical name in iteration n can then be read under the next-higher logical name in iteration n+1. This lets overlapped loop iterations reuse the same names without overwriting each other.

There are two combinational read ports and one write port. A base clear input returns the base to zero. The region sizes and the data width are parameters; the default is 32 static and 96 rotating entries of 64 bits. All ports are plain control and data pins. There is no valid/ready handshake and no back-pressure: a write presented with `wr_en` high is taken at that clock edge, and a read address is answered in the same cycle.

Top module: `rrf_renamer`

## Requirements
- R1: After reset the base is zero and every logical register reads zero.
- R2: A logical index below the static count (32 by default) always selects the same static entry, whatever the base, and rotation never moves its contents.
- R3: A logical index L at or above the static count S selects rotating entry ((L - S) + base) mod NR, where NR is the rotating-region size (96 by default). A value written at L is therefore read at L+k after k rotations, and logical S+NR-1 wraps to logical S.
- R4: Each rotate strobe without clear lowers the base by one, and the base wraps from 0 to NR-1. NR consecutive rotations bring the base back to its starting value.
- R5: A write issued in the same cycle as a rotate strobe is placed using the base value from before that rotation.
- R6: Base clear sets the base to zero at the next edge, and clear wins over a simultaneous rotate.
- R7: A read of the physical entry being written in the same cycle returns the write data (write-first bypass), on both read ports.
- R8: The two read ports are independent and can return different registers in the same cycle.
- R9: With `wr_en` low, no entry changes, whatever is on the write address and data pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rot_adv | input | 1 | Rotate strobe, end of a loop iteration |
| base_clr | input | 1 | Set the rotating base to zero |
| wr_en | input | 1 | Write enable |
| wr_lreg | input | LW (7) | Logical register to write |
| wr_data | input | DW (64) | Write data |
| rd0_lreg | input | LW (7) | Logical register for read port 0 |
| rd0_data | output | DW (64) | Read port 0 data, combinational |
| rd1_lreg | input | LW (7) | Logical register for read port 1 |
| rd1_data | output | DW (64) | Read port 1 data, combinational |

## Verification
The hardest situation to reach from the ports is a rotating base that has wrapped below zero. A value must then be followed across that wrap and across the top of the rotating region, while the base itself is never visible. The stimulus writes tagged values and rotates, sometimes in the same cycle as the write. It then reads them back under shifted logical names chosen so that the modular sum crosses NR. Finally it runs a full lap of NR rotations and checks that the original name finds the original value again.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
  localparam int unsigned RRF_NSTAT_DEF = 32;
  localparam int unsigned RRF_NROT_DEF  = 96;
  localparam int unsigned RRF_DW_DEF    = 64;
  localparam int unsigned RRF_NRD       = 2;
endpackage

// File: rtl/rrf_base_ctr.sv
module rrf_base_ctr #(
  parameter int unsigned NR = 96,
  localparam int unsigned BW = $clog2(NR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          clr,
  output logic [BW-1:0] base
);
  localparam logic [BW-1:0] TOP = BW'(NR - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)     base <= '0;
    else if (clr)   base <= '0;
    else if (adv)   base <= (base == '0) ? TOP : base - 1'b1;
  end
endmodule

// File: rtl/rrf_map.sv
module rrf_map #(
  parameter int unsigned NS = 32,
  parameter int unsigned NR = 96,
  localparam int unsigned TOT = NS + NR,
  localparam int unsigned LW = $clog2(TOT),
  localparam int unsigned BW = $clog2(NR),
  localparam int unsigned EW = LW + 1
) (
  input  logic [LW-1:0] lreg,
  input  logic [BW-1:0] base,
  output logic [LW-1:0] phys,
  output logic          ok
);
  localparam logic [EW-1:0] NS_E  = EW'(NS);
  localparam logic [EW-1:0] NR_E  = EW'(NR);
  localparam logic [EW-1:0] TOT_E = EW'(TOT);

  logic [EW-1:0] lx, off, sum;

  always_comb begin
    lx   = EW'(lreg);
    ok   = lx < TOT_E;
    off  = lx - NS_E;
    sum  = off + EW'(base);
    if (sum >= NR_E) sum = sum - NR_E;
    if (lx < NS_E) phys = lreg;
    else           phys = LW'(sum + NS_E);
  end
endmodule

// File: rtl/rrf_store.sv
module rrf_store #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned DW    = 64,
  parameter int unsigned NRD   = 2,
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [PW-1:0]            wa,
  input  logic [DW-1:0]            wd,
  input  logic [NRD-1:0][PW-1:0]   ra,
  output logic [NRD-1:0][DW-1:0]   rd
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wa] <= wd;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd[g] = (we && (wa == ra[g])) ? wd : mem[ra[g]];
  end
endmodule

// File: rtl/rrf_renamer.sv
module rrf_renamer
  import rrf_pkg::*;
#(
  parameter int unsigned NS = RRF_NSTAT_DEF,
  parameter int unsigned NR = RRF_NROT_DEF,
  parameter int unsigned DW = RRF_DW_DEF,
  localparam int unsigned TOT = NS + NR,
  localparam int unsigned LW = $clog2(TOT),
  localparam int unsigned BW = $clog2(NR),
  localparam int unsigned NP = RRF_NRD + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rot_adv,
  input  logic          base_clr,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_lreg,
  input  logic [DW-1:0] wr_data,
  input  logic [LW-1:0] rd0_lreg,
  output logic [DW-1:0] rd0_data,
  input  logic [LW-1:0] rd1_lreg,
  output logic [DW-1:0] rd1_data
);
  logic [BW-1:0]               base_q;
  logic [NP-1:0][LW-1:0]       lregs;
  logic [NP-1:0][LW-1:0]       phys;
  logic [NP-1:0]               ok;
  logic [RRF_NRD-1:0][LW-1:0]  ra;
  logic [RRF_NRD-1:0][DW-1:0]  rdat;
  logic [LW-1:0]               wr_phys, rd0_phys, rd1_phys;
  logic                        wr_ok, rd0_ok, rd1_ok;

  rrf_base_ctr #(.NR(NR)) u_base (
    .clk(clk), .rst_n(rst_n), .adv(rot_adv), .clr(base_clr), .base(base_q)
  );

  assign lregs[0] = wr_lreg;
  assign lregs[1] = rd0_lreg;
  assign lregs[2] = rd1_lreg;

  for (genvar p = 0; p < NP; p++) begin : g_map
    rrf_map #(.NS(NS), .NR(NR)) u_map (
      .lreg(lregs[p]), .base(base_q), .phys(phys[p]), .ok(ok[p])
    );
  end

  assign wr_phys  = phys[0];
  assign rd0_phys = phys[1];
  assign rd1_phys = phys[2];
  assign wr_ok    = ok[0];
  assign rd0_ok   = ok[1];
  assign rd1_ok   = ok[2];
  assign ra[0]    = rd0_phys;
  assign ra[1]    = rd1_phys;

  rrf_store #(.DEPTH(TOT), .DW(DW), .NRD(RRF_NRD)) u_store (
    .clk(clk), .rst_n(rst_n), .we(wr_en && wr_ok), .wa(wr_phys), .wd(wr_data),
    .ra(ra), .rd(rdat)
  );

  assign rd0_data = rd0_ok ? rdat[0] : '0;
  assign rd1_data = rd1_ok ? rdat[1] : '0;
endmodule

// File: rtl/rrf_renamer_chk.sv
module rrf_renamer_chk #(
  parameter int unsigned NS = 32,
  parameter int unsigned NR = 96,
  parameter int unsigned DW = 64,
  localparam int unsigned LW = $clog2(NS + NR),
  localparam int unsigned BW = $clog2(NR)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rot_adv,
  input logic          base_clr,
  input logic          wr_en,
  input logic          wr_ok,
  input logic          rd0_ok,
  input logic          rd1_ok,
  input logic [BW-1:0] base,
  input logic [LW-1:0] wr_phys,
  input logic [LW-1:0] rd0_phys,
  input logic [LW-1:0] rd1_phys,
  input logic [LW-1:0] rd0_lreg,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] rd0_data,
  input logic [DW-1:0] rd1_data
);
  localparam logic [BW-1:0] TOP = BW'(NR - 1);

  a_r4_rot_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (rot_adv && !base_clr) |=> base == (($past(base) == '0) ? TOP : $past(base) - 1'b1));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rot_adv && !base_clr) |=> $stable(base));

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    base_clr |=> base == '0);

  a_r3_base_range: assert property (@(posedge clk) disable iff (!rst_n)
    base <= TOP);

  a_r2_static_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_lreg < LW'(NS)) |-> rd0_phys == rd0_lreg);

  a_r7_bypass_rd0: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ok && rd0_ok && rd0_phys == wr_phys) |-> rd0_data == wr_data);

  a_r7_bypass_rd1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ok && rd1_ok && rd1_phys == wr_phys) |-> rd1_data == wr_data);
endmodule

bind rrf_renamer rrf_renamer_chk #(.NS(NS), .NR(NR), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rot_adv(rot_adv), .base_clr(base_clr),
  .wr_en(wr_en), .wr_ok(wr_ok), .rd0_ok(rd0_ok), .rd1_ok(rd1_ok),
  .base(base_q), .wr_phys(wr_phys), .rd0_phys(rd0_phys), .rd1_phys(rd1_phys),
  .rd0_lreg(rd0_lreg), .wr_data(wr_data), .rd0_data(rd0_data), .rd1_data(rd1_data)
);

// File: tb/tb_rrf_renamer.sv
`timescale 1ns/1ps
module tb_rrf_renamer;
  localparam int LW = 7;
  localparam int DW = 64;
  localparam int VW = 1 + LW + DW + 1 + LW + DW + LW + DW;
  localparam int NSTEP = 9;

  localparam logic [DW-1:0] A1 = 64'h1111_0000_0000_00A1;
  localparam logic [DW-1:0] A2 = 64'h2222_0000_0000_00A2;
  localparam logic [DW-1:0] A3 = 64'h3333_0000_0000_00A3;
  localparam logic [DW-1:0] A4 = 64'h4444_0000_0000_00A4;
  localparam logic [DW-1:0] Z  = 64'h0;

  // fields: wr_en, wr_lreg, wr_data, rot, rd0_lreg, rd0_exp, rd1_lreg, rd1_exp
  localparam logic [VW-1:0] TBL [NSTEP] = '{
    {1'b1, 7'd32,  A1, 1'b0, 7'd32,  A1, 7'd40, Z },   // base 0, bypass
    {1'b1, 7'd40,  A2, 1'b1, 7'd32,  A1, 7'd40, A2},   // write+rotate, old base
    {1'b0, 7'd0,   Z,  1'b0, 7'd33,  A1, 7'd41, A2},   // base 95
    {1'b0, 7'd0,   Z,  1'b1, 7'd41,  A2, 7'd33, A1},
    {1'b0, 7'd0,   Z,  1'b0, 7'd34,  A1, 7'd42, A2},   // base 94
    {1'b1, 7'd5,   A3, 1'b1, 7'd5,   A3, 7'd35, Z },   // static write, bypass
    {1'b0, 7'd0,   Z,  1'b0, 7'd5,   A3, 7'd4,  Z },   // base 93
    {1'b1, 7'd127, A4, 1'b1, 7'd127, A4, 7'd5,  A3},   // top of region
    {1'b0, 7'd0,   Z,  1'b0, 7'd32,  A4, 7'd44, A2}    // base 92, wrap 127->32
  };
  localparam string TAG [NSTEP] = '{"R7", "R5", "R3", "R3", "R3", "R2", "R2", "R7", "R3"};

  logic clk = 1'b0;
  logic rst_n, rot_adv, base_clr, wr_en;
  logic [LW-1:0] wr_lreg, rd0_lreg, rd1_lreg;
  logic [DW-1:0] wr_data, rd0_data, rd1_data;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rrf_renamer dut (
    .clk(clk), .rst_n(rst_n), .rot_adv(rot_adv), .base_clr(base_clr),
    .wr_en(wr_en), .wr_lreg(wr_lreg), .wr_data(wr_data),
    .rd0_lreg(rd0_lreg), .rd0_data(rd0_data),
    .rd1_lreg(rd1_lreg), .rd1_data(rd1_data)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 1'b0; rot_adv = 1'b0; base_clr = 1'b0;
    wr_lreg = '0; wr_data = '0;
  endtask

  task automatic read2(input logic [LW-1:0] a, input logic [LW-1:0] b);
    @(negedge clk);
    idle();
    rd0_lreg = a; rd1_lreg = b;
    #1;
  endtask

  initial begin
    #1000000;
    checks++;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    if (!done) $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; idle(); rd0_lreg = '0; rd1_lreg = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state
    read2(7'd0, 7'd127);
    chk("R1 rd0", rd0_data, Z);
    chk("R1 rd1", rd1_data, Z);

    for (int i = 0; i < NSTEP; i++) begin
      logic f_we, f_rot;
      logic [LW-1:0] f_wl, f_r0l, f_r1l;
      logic [DW-1:0] f_wd, f_r0e, f_r1e;
      {f_we, f_wl, f_wd, f_rot, f_r0l, f_r0e, f_r1l, f_r1e} = TBL[i];
      @(negedge clk);
      wr_en = f_we; wr_lreg = f_wl; wr_data = f_wd; rot_adv = f_rot; base_clr = 1'b0;
      rd0_lreg = f_r0l; rd1_lreg = f_r1l;
      #1;
      chk({TAG[i], " rd0"}, rd0_data, f_r0e);
      chk({TAG[i], " rd1"}, rd1_data, f_r1e);
    end

    // R9: disabled write leaves entry alone (base 92, logical 32 holds A4)
    @(negedge clk);
    idle(); wr_lreg = 7'd32; wr_data = 64'hFFFF_FFFF_FFFF_FFFF; rd0_lreg = 7'd32;
    read2(7'd32, 7'd32);
    chk("R9 no write", rd0_data, A4);

    // R6: clear beats rotate; base 0 -> logical 124 maps to entry 92 (A4)
    @(negedge clk);
    idle(); base_clr = 1'b1; rot_adv = 1'b1;
    read2(7'd124, 7'd125);
    chk("R6 clear rd0", rd0_data, A4);
    chk("R6 clear rd1", rd1_data, Z);

    // R4: wrap from 0 to 95, then full lap returns
    @(negedge clk);
    idle(); rot_adv = 1'b1;
    read2(7'd125, 7'd124);
    chk("R4 wrap", rd0_data, A4);
    for (int k = 0; k < 95; k++) begin
      @(negedge clk);
      idle(); rot_adv = 1'b1;
    end
    read2(7'd124, 7'd5);
    chk("R4 full lap", rd0_data, A4);
    chk("R2 static after rotations", rd1_data, A3);

    // R8: two ports, different registers
    read2(7'd5, 7'd124);
    chk("R8 rd0", rd0_data, A3);
    chk("R8 rd1", rd1_data, A4);

    // R1: reset clears contents
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    read2(7'd5, 7'd124);
    chk("R1 after reset rd0", rd0_data, Z);
    chk("R1 after reset rd1", rd1_data, Z);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule